// File: doc/BRIEF.md
# Two-Bank Flash Write Sequencer

This block sits on the host side of a flash device that has two banks and refuses writes unless each one is preceded by an unlock sequence. A client hands over one request at a time: a word program, a sector erase, a block erase or a whole-bank erase, together with a target address and, for a program, the data word. The sequencer drives the unlock writes and the command write onto a simple synchronous memory port. It then watches the device's toggling status bit until the operation has settled, and reports back with a one-cycle done pulse and an error flag.

Completion is judged only from the status bit 6 of reads to the target location. Two reads in a row that agree mean the operation may be over. Because a status read can land exactly on the moment the operation finishes, two further agreeing reads are required before the result is taken. A program request ends with a comparison of the final read against the requested word. A poll budget turns a hung device into an error rather than a stall. The target word of a program must already be erased when the request is issued. Reads of the other bank by other masters are not this block's concern.

Top module: `flash_wr_seq`

## Requirements
- R1: A program request (req_op = 0) produces exactly four writes, in this order: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (target address, request data); command data sits in the low 8 bits with the upper data bits zero, and unlock addresses have all bits above bit 14 zero.
- R2: An erase request produces exactly six writes: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), then a final command write whose data is 0x30 for sector erase (req_op = 1), 0x50 for block erase (req_op = 2) and 0x10 for bank erase (req_op = 3); for sector and block erase the final address is the target address.
- R3: For a bank erase the final write address is 0x5555 with the target's bank bit (the top address bit) copied into the top bit.
- R4: After the last command write the block only reads, one read every second cycle, always at the target address, and never writes and reads in the same cycle.
- R5: The operation is taken as complete at the first read whose bit 6 equals bit 6 of each of the three reads before it; the number of reads equals the index of that read.
- R6: If no completion is seen within MAX_POLLS reads, the block stops after exactly MAX_POLLS reads and reports done with err = 1.
- R7: For a program request, err is 1 if the completing read differs from the request data in any bit; for erases, a completion gives err = 0.
- R8: req_ready falls in the cycle after a request is accepted and stays low until after the done pulse; a request held valid during that time starts nothing.
- R9: done is high for exactly one cycle; err keeps its value from that done pulse until the next request is accepted.
- R10: After reset req_ready is 1 and done, err, mem_we and mem_re are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 bank erase |
| req_addr | input | ADDR_W | Target address; top bit selects the bank |
| req_data | input | DATA_W | Word to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last operation |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns the next cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after mem_re |

## Verification
Every operation type is run against a device model that toggles bit 6 for a chosen number of busy reads with either starting phase, swept from zero busy reads upward. The cases where the last toggling read happens to equal the settled value separate a block that takes the first agreeing pair from one that waits for confirmation. A device that never settles probes the poll budget, a corrupted final word on a program probes the read-back, and bank erases with both bank bit values tell apart a final address that carries the bank from one that loses it.

// File: rtl/fws_pkg.sv
package fws_pkg;
   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_BLK  = 2'd2,
      OP_BANK = 2'd3
   } fws_op_e;

   localparam logic [14:0] UNLOCK_A = 15'h5555;
   localparam logic [14:0] UNLOCK_B = 15'h2AAA;
   localparam logic [7:0]  KEY_1    = 8'hAA;
   localparam logic [7:0]  KEY_2    = 8'h55;
   localparam logic [7:0]  CMD_PROG = 8'hA0;
   localparam logic [7:0]  CMD_ERS  = 8'h80;
   localparam logic [7:0]  CMD_SECT = 8'h30;
   localparam logic [7:0]  CMD_BLK  = 8'h50;
   localparam logic [7:0]  CMD_BANK = 8'h10;
endpackage

// File: rtl/fws_cmd_table.sv
module fws_cmd_table
   import fws_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 16,
   parameter int BANK_ON_UNLOCK = 0
) (
   input  fws_op_e             op,
   input  logic [2:0]          step,
   input  logic [ADDR_W-1:0]   tgt_addr,
   input  logic [DATA_W-1:0]   tgt_data,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                wr_last
);
   localparam int HI_W = ADDR_W - 15;

   logic [ADDR_W-1:0] bank_hi;
   logic [ADDR_W-1:0] ua_a, ua_b, bank_final;

   assign bank_hi = {tgt_addr[ADDR_W-1], {(ADDR_W-1){1'b0}}};

   generate
      if (BANK_ON_UNLOCK != 0) begin : g_bank_unlock
         assign ua_a = bank_hi | {{HI_W{1'b0}}, UNLOCK_A};
         assign ua_b = bank_hi | {{HI_W{1'b0}}, UNLOCK_B};
      end else begin : g_plain_unlock
         assign ua_a = {{HI_W{1'b0}}, UNLOCK_A};
         assign ua_b = {{HI_W{1'b0}}, UNLOCK_B};
      end
   endgenerate

   assign bank_final = bank_hi | {{HI_W{1'b0}}, UNLOCK_A};

   function automatic logic [DATA_W-1:0] cw(input logic [7:0] c);
      return {{(DATA_W-8){1'b0}}, c};
   endfunction

   always_comb begin
      wr_addr = ua_a;
      wr_data = cw(KEY_1);
      wr_last = 1'b0;
      if (op == OP_PROG) begin
         case (step)
            3'd0: begin wr_addr = ua_a; wr_data = cw(KEY_1); end
            3'd1: begin wr_addr = ua_b; wr_data = cw(KEY_2); end
            3'd2: begin wr_addr = ua_a; wr_data = cw(CMD_PROG); end
            default: begin wr_addr = tgt_addr; wr_data = tgt_data; wr_last = 1'b1; end
         endcase
      end else begin
         case (step)
            3'd0, 3'd3: begin wr_addr = ua_a; wr_data = cw(KEY_1); end
            3'd1, 3'd4: begin wr_addr = ua_b; wr_data = cw(KEY_2); end
            3'd2:       begin wr_addr = ua_a; wr_data = cw(CMD_ERS); end
            default: begin
               wr_last = 1'b1;
               case (op)
                  OP_SECT: begin wr_addr = tgt_addr;   wr_data = cw(CMD_SECT); end
                  OP_BLK:  begin wr_addr = tgt_addr;   wr_data = cw(CMD_BLK);  end
                  default: begin wr_addr = bank_final; wr_data = cw(CMD_BANK); end
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/fws_poll_track.sv
module fws_poll_track #(
   parameter int MAX_POLLS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic sample,
   input  logic bit_in,
   output logic settled,
   output logic exhausted
);
   localparam int CNT_W = $clog2(MAX_POLLS + 1);

   logic             have_prev;
   logic             prev_bit;
   logic [1:0]       agree;
   logic [CNT_W-1:0] reads;
   logic             match;

   assign match     = have_prev && (bit_in == prev_bit);
   assign settled   = sample && match && (agree == 2'd2);
   assign exhausted = sample && (reads == CNT_W'(MAX_POLLS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_bit  <= 1'b0;
         agree     <= 2'd0;
         reads     <= '0;
      end else if (clear) begin
         have_prev <= 1'b0;
         agree     <= 2'd0;
         reads     <= '0;
      end else if (sample) begin
         reads     <= reads + 1'b1;
         have_prev <= 1'b1;
         prev_bit  <= bit_in;
         if (match) begin
            if (agree != 2'd3) agree <= agree + 2'd1;
         end else begin
            agree <= 2'd0;
         end
      end
   end
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
   import fws_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 16,
   parameter int MAX_POLLS      = 64,
   parameter int BANK_ON_UNLOCK = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              done,
   output logic              err,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (ADDR_W < 16) begin : g_bad_aw
         $error("flash_wr_seq: ADDR_W must be at least 16");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("flash_wr_seq: DATA_W must be at least 8");
      end
      if (MAX_POLLS < 4) begin : g_bad_polls
         $error("flash_wr_seq: MAX_POLLS must be at least 4");
      end
   endgenerate

   typedef enum logic [2:0] {S_IDLE, S_WR, S_RISS, S_RWAIT, S_DONE} st_e;

   st_e               st;
   fws_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [2:0]        step;
   logic              err_q;

   logic [ADDR_W-1:0] tab_addr;
   logic [DATA_W-1:0] tab_data;
   logic              tab_last;
   logic              settled, exhausted;

   fws_cmd_table #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_ON_UNLOCK(BANK_ON_UNLOCK)
   ) u_table (
      .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
      .wr_addr(tab_addr), .wr_data(tab_data), .wr_last(tab_last)
   );

   fws_poll_track #(.MAX_POLLS(MAX_POLLS)) u_poll (
      .clk(clk), .rst_n(rst_n),
      .clear(st == S_IDLE), .sample(st == S_RWAIT), .bit_in(mem_rdata[6]),
      .settled(settled), .exhausted(exhausted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         step   <= 3'd0;
         err_q  <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               op_q   <= fws_op_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               step   <= 3'd0;
               err_q  <= 1'b0;
               st     <= S_WR;
            end
            S_WR: begin
               step <= step + 3'd1;
               if (tab_last) st <= S_RISS;
            end
            S_RISS: st <= S_RWAIT;
            S_RWAIT: begin
               if (settled) begin
                  err_q <= (op_q == OP_PROG) && (mem_rdata != data_q);
                  st    <= S_DONE;
               end else if (exhausted) begin
                  err_q <= 1'b1;
                  st    <= S_DONE;
               end else begin
                  st <= S_RISS;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (st == S_IDLE);
   assign done      = (st == S_DONE);
   assign err       = err_q;
   assign mem_we    = (st == S_WR);
   assign mem_re    = (st == S_RISS);
   assign mem_addr  = (st == S_WR) ? tab_addr : (st == S_RISS) ? addr_q : '0;
   assign mem_wdata = (st == S_WR) ? tab_data : '0;
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
   parameter int MAX_POLLS = 64
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic done,
   input logic err,
   input logic mem_we,
   input logic mem_re
);
   localparam int CNT_W = $clog2(MAX_POLLS + 2);
   logic [CNT_W-1:0] rd_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_seen <= '0;
      else if (req_valid && req_ready) rd_seen <= '0;
      else if (mem_re) rd_seen <= rd_seen + 1'b1;
   end

   p_no_rw_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_ready_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready);
   p_err_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> $stable(err));
   p_poll_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> (rd_seen < CNT_W'(MAX_POLLS)));
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_we && !mem_re && !done));
endmodule

bind flash_wr_seq fws_checker #(.MAX_POLLS(MAX_POLLS)) u_fws_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .done(done), .err(err), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/flash_wr_seq_tb.sv
module flash_wr_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;
   localparam int DW = 16;
   localparam int MAXP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          done, err, mem_we, mem_re;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP), .BANK_ON_UNLOCK(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .done(done), .err(err), .mem_we(mem_we), .mem_re(mem_re),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // device model
   logic          m_clr = 1'b0;
   int            m_busy = 0;
   int            m_ph = 0;
   logic [DW-1:0] m_fin = '0;
   logic [AW-1:0] m_addr = '0;
   int            nw, nr;
   logic          late_wr, bad_ra;
   logic [AW-1:0] wa [8];
   logic [DW-1:0] wd [8];

   always @(posedge clk) begin
      if (m_clr) begin
         nw <= 0; nr <= 0; late_wr <= 1'b0; bad_ra <= 1'b0;
         mem_rdata <= '0;
      end else begin
         if (mem_we) begin
            if (nw < 8) begin wa[nw] <= mem_addr; wd[nw] <= mem_wdata; end
            nw <= nw + 1;
            if (nr > 0) late_wr <= 1'b1;
         end
         if (mem_re) begin
            nr <= nr + 1;
            if (mem_addr != m_addr) bad_ra <= 1'b1;
            if (nr + 1 <= m_busy)
               mem_rdata <= (m_fin & ~DW'(64)) | (DW'((((nr + 1) & 1) ^ m_ph) & 1) << 6);
            else
               mem_rdata <= m_fin;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_wa(input int op, input int i, input logic [AW-1:0] a);
      if (i == 0 || i == 3 && op != 0) return 'h5555;
      if (i == 1 || i == 4) return 'h2AAA;
      if (i == 2) return 'h5555;
      if (op == 0 || op == 1 || op == 2) return int'(a);
      return (int'(a[AW-1]) << (AW-1)) | 'h5555;
   endfunction

   function automatic int exp_wd(input int op, input int i, input logic [DW-1:0] d);
      if (i == 0 || i == 3 && op != 0) return 'hAA;
      if (i == 1 || i == 4) return 'h55;
      if (i == 2) return (op == 0) ? 'hA0 : 'h80;
      if (op == 0) return int'(d);
      if (op == 1) return 'h30;
      if (op == 2) return 'h50;
      return 'h10;
   endfunction

   // index of first read whose bit 6 equals the three before it
   function automatic int settle_idx(input int busy, input int ph, input int fin6);
      int run = 0;
      int prevb = -1;
      for (int i = 1; i <= 200; i++) begin
         int b = (i <= busy) ? ((i & 1) ^ ph) : fin6;
         run = (b == prevb) ? run + 1 : 1;
         prevb = b;
         if (run >= 4) return i;
      end
      return 1000;
   endfunction

   task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int busy, input int ph, input logic [DW-1:0] fin);
      int k, exp_rd, nlen, cyc;
      bit exp_err, got_err, ready_ok;
      @(negedge clk);
      m_busy = busy; m_ph = ph; m_fin = fin; m_addr = a; m_clr = 1'b1;
      @(negedge clk);
      m_clr = 1'b0;
      req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
      @(negedge clk);
      // keep a different request valid while busy: must start nothing (R8)
      req_op = 2'(3 - op); req_addr = ~a; req_data = ~d;
      ready_ok = 1'b1; cyc = 0; got_err = 1'b0;
      while (!done && cyc < 500) begin
         if (req_ready) ready_ok = 1'b0;
         @(negedge clk);
         cyc++;
      end
      check(cyc < 500, "R9 watchdog", cyc, 0);
      got_err = err;
      req_valid = 1'b0;
      check(ready_ok, "R8 ready low while busy", 1, 0);
      k = settle_idx(busy, ph, int'(fin[6]));
      exp_rd = (k > MAXP) ? MAXP : k;
      exp_err = (k > MAXP) || (op == 0 && fin != d);
      nlen = (op == 0) ? 4 : 6;
      check(got_err == exp_err, (k > MAXP) ? "R6 timeout err" : "R7 err value",
            int'(got_err), int'(exp_err));
      check(nr == exp_rd, (k > MAXP) ? "R6 read count" : "R5 read count", nr, exp_rd);
      check(nw == nlen, (op == 0) ? "R1 write count" : "R2 write count", nw, nlen);
      for (int i = 0; i < nlen && i < 8; i++) begin
         check(int'(wa[i]) == exp_wa(op, i, a),
               (op == 3 && i == 5) ? "R3 bank final addr" : ((op == 0) ? "R1 addr" : "R2 addr"),
               int'(wa[i]), exp_wa(op, i, a));
         check(int'(wd[i]) == exp_wd(op, i, d), (op == 0) ? "R1 data" : "R2 data",
               int'(wd[i]), exp_wd(op, i, d));
      end
      check(!late_wr && !bad_ra, "R4 reads only at target", int'({late_wr, bad_ra}), 0);
      @(negedge clk);
      check(!done && req_ready, "R9 done one cycle", int'({done, req_ready}), 1);
      check(err == exp_err, "R9 err held", int'(err), int'(exp_err));
   endtask

   initial begin
      m_clr = 1'b1;
      repeat (3) @(negedge clk);
      check(req_ready && !done && !err && !mem_we && !mem_re, "R10 reset state",
            int'({req_ready, done, err, mem_we, mem_re}), 'h10);
      rst_n = 1'b1;
      @(negedge clk);
      m_clr = 1'b0;
      // program sweep over busy length and toggle phase (R1 R5 R7)
      for (int b = 0; b <= 6; b++)
         for (int p = 0; p < 2; p++)
            run_op(0, 20'h1_2345 + AW'(b), 16'hBEEF ^ DW'(p << 6), b, p, 16'hBEEF ^ DW'(p << 6));
      // erases, both banks (R2 R3)
      for (int op = 1; op <= 3; op++)
         for (int b = 0; b <= 4; b += 2) begin
            run_op(op, 20'h0_4321, 16'h0, b, b & 1, 16'hFFFF);
            run_op(op, 20'h8_7654, 16'h0, b + 1, 0, 16'hFFFF);
         end
      // never settles (R6)
      run_op(0, 20'h3_0000, 16'h1234, 100, 0, 16'h1234);
      run_op(3, 20'hF_0000, 16'h0, 100, 1, 16'hFFFF);
      // read-back mismatch in bit 0 only (R7)
      run_op(0, 20'h2_0002, 16'h00C3, 3, 0, 16'h00C2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule